// File: doc/BRIEF.md
# Lane Synchronization Controller

This block decides, for one receive lane of an 8b/10b serial link, when the lane is aligned and in sync. For each received code group, an upstream decoder and comma detector supply a valid strobe, a comma flag with the alignment offset where the comma was found, and decode and running-disparity error flags. A loss-of-signal input is also provided. The controller returns four outputs: a lane-sync status bit, an enable that allows the word aligner to move its boundary, the offset it has locked onto, and a request for the receive data path to substitute a local fault.

To acquire the lane, the controller needs four commas. The first one fixes the offset. The next two must arrive at that same offset. The last one may arrive at any offset. Once in sync, the controller tolerates short bursts of errors through a ladder of three miss levels. Three clean codes in a row climb back one level. However, only the first miss level returns directly to full sync, so a lane that has slipped deeper needs two clean runs to fully recover. A fourth error without recovery drops the lane.

Top module: `lane_sync_fsm`

## Requirements
- R1: After reset the lane is unsynchronized: `lane_synced`=0, `realign_en`=1, `fault_req`=1 and `align_pos`=0.
- R2: `sig_lost` high on any cycle returns the lane to the unsynchronized state on the next edge (`lane_synced`=0, `realign_en`=1), whatever the other inputs are.
- R3: `realign_en` is 1 only in the unsynchronized state. A valid error-free comma there stores its `comma_pos` into `align_pos` and starts acquisition, which drops `realign_en` on the next edge.
- R4: Four valid error-free commas are needed to reach sync: the first starts acquisition, and the second and third must match `align_pos`. `lane_synced` rises after the fourth.
- R5: During the first two acquisition steps, a comma at an offset other than `align_pos` returns the lane to unsynchronized. In the last acquisition step, a comma at any offset completes sync.
- R6: A decode or disparity error on a valid code during acquisition returns the lane to unsynchronized.
- R7: `fault_req` is always the inverse of `lane_synced`. `lane_synced` stays 1 in sync and in every miss level.
- R8: In sync, an error enters miss level 1. Three consecutive error-free valid codes in miss level 1 return the lane to sync.
- R9: An error in miss level 1 goes to level 2, in level 2 goes to level 3, and in level 3 drops to unsynchronized. Three clean codes in level 2 or level 3 return the lane to level 1, not to sync.
- R10: The clean-code count restarts on entry to each miss level, so clean codes seen before an error do not count toward the next recovery.
- R11: Cycles with `code_vld`=0 change no state, whatever the error and comma inputs are.
- R12: When a code carries both a comma and an error, the error decides the transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Code-group clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_vld | input | 1 | A decoded code group is present this cycle |
| comma_det | input | 1 | The code group is a comma |
| comma_pos | input | POS_W | Alignment offset at which the comma was found |
| dec_err | input | 1 | Invalid code group |
| disp_err | input | 1 | Running disparity error |
| sig_lost | input | 1 | Loss of signal on the lane |
| lane_synced | output | 1 | Lane synchronized |
| realign_en | output | 1 | Word aligner may shift its boundary |
| align_pos | output | POS_W | Offset captured when acquisition began |
| fault_req | output | 1 | Request local fault on the receive data path |

## Verification
The acquisition sequence is tried in four forms: with every comma at the same offset, with an offset change in the first and second steps, with an offset change in the last step, and with an error arriving on the same code as a comma. Together these separate the strict offset check from the lenient final step, and show that errors take priority over commas.

The miss ladder is exercised with interleaved clean runs and errors. Because only `lane_synced` is visible at the ports, each test counts how many further errors it takes to drop the lane, which tells apart a return to sync from a return to miss level 1. It also tells apart a counter that is cleared on entry from one that carries old clean codes forward.

Invalid cycles that carry error flags, and loss of signal arriving mid-sync, show that the strobe gates every transition and that loss of signal overrides all other transitions.

// File: rtl/lane_sync_pkg.sv
package lane_sync_pkg;

  typedef enum logic [2:0] {
    S_SEEK  = 3'd0,
    S_CONF1 = 3'd1,
    S_CONF2 = 3'd2,
    S_CONF3 = 3'd3,
    S_LOCK  = 3'd4,
    S_SLIP1 = 3'd5,
    S_SLIP2 = 3'd6,
    S_SLIP3 = 3'd7
  } lsync_state_e;

  function automatic logic f_in_slip(lsync_state_e s);
    return (s == S_SLIP1) || (s == S_SLIP2) || (s == S_SLIP3);
  endfunction

  function automatic logic f_synced(lsync_state_e s);
    return (s == S_LOCK) || f_in_slip(s);
  endfunction

  function automatic logic f_in_conf(lsync_state_e s);
    return (s == S_CONF1) || (s == S_CONF2) || (s == S_CONF3);
  endfunction

  // one step deeper on an error; past the last level the lane is lost
  function automatic lsync_state_e f_deeper(lsync_state_e s);
    case (s)
      S_LOCK:  return S_SLIP1;
      S_SLIP1: return S_SLIP2;
      S_SLIP2: return S_SLIP3;
      default: return S_SEEK;
    endcase
  endfunction

  // a clean run climbs one level; levels 2 and 3 land on level 1
  function automatic lsync_state_e f_recover(lsync_state_e s);
    return (s == S_SLIP1) ? S_LOCK : S_SLIP1;
  endfunction

  function automatic lsync_state_e f_step_up(lsync_state_e s);
    case (s)
      S_SEEK:  return S_CONF1;
      S_CONF1: return S_CONF2;
      S_CONF2: return S_CONF3;
      default: return S_LOCK;
    endcase
  endfunction

endpackage

// File: rtl/lsync_good_run.sv
module lsync_good_run #(
  parameter int RUN_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic run_done
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

  logic [CNT_W-1:0] cnt;

  assign run_done = inc && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  // R10: the count never runs past the recovery length
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R10: a clear always restarts the count
  p_cnt_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);

endmodule

// File: rtl/lsync_pos_cap.sv
module lsync_pos_cap #(
  parameter int POS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [POS_W-1:0] pos_in,
  output logic [POS_W-1:0] pos_q,
  output logic             pos_match
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pos_q <= '0;
    else if (load)  pos_q <= pos_in;
  end

  assign pos_match = (pos_in == pos_q);

  // R3: a capture holds the offset presented on the loading cycle
  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pos_q == $past(pos_in));

endmodule

// File: rtl/lane_sync_fsm.sv
module lane_sync_fsm
  import lane_sync_pkg::*;
#(
  parameter int POS_W   = 4,
  parameter int RUN_LEN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             code_vld,
  input  logic             comma_det,
  input  logic [POS_W-1:0] comma_pos,
  input  logic             dec_err,
  input  logic             disp_err,
  input  logic             sig_lost,
  output logic             lane_synced,
  output logic             realign_en,
  output logic [POS_W-1:0] align_pos,
  output logic             fault_req
);

  lsync_state_e state, nxt;

  // named events for the assertions and the submodules
  logic code_err, code_good, comma_ok, pos_match, run_done;
  logic cap_load, run_inc, run_clr;

  assign code_err  = code_vld && (dec_err || disp_err) && !sig_lost;
  assign code_good = code_vld && !dec_err && !disp_err && !sig_lost;
  assign comma_ok  = code_good && comma_det;

  assign cap_load = (state == S_SEEK) && comma_ok;
  assign run_inc  = f_in_slip(state) && code_good;
  assign run_clr  = (nxt != state);

  lsync_pos_cap #(.POS_W(POS_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .load(cap_load), .pos_in(comma_pos),
    .pos_q(align_pos), .pos_match(pos_match)
  );

  lsync_good_run #(.RUN_LEN(RUN_LEN)) u_run (
    .clk(clk), .rst_n(rst_n), .clr(run_clr), .inc(run_inc),
    .run_done(run_done)
  );

  always_comb begin
    nxt = state;
    if (sig_lost) begin
      nxt = S_SEEK;
    end else if (code_err) begin
      nxt = (state == S_SEEK || f_in_conf(state)) ? S_SEEK : f_deeper(state);
    end else if (code_vld) begin
      case (state)
        S_SEEK:           if (comma_det) nxt = S_CONF1;
        S_CONF1, S_CONF2: if (comma_det) nxt = pos_match ? f_step_up(state) : S_SEEK;
        S_CONF3:          if (comma_det) nxt = S_LOCK;
        S_SLIP1, S_SLIP2, S_SLIP3:
                          if (run_done)  nxt = f_recover(state);
        default:          nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_SEEK;
    else        state <= nxt;
  end

  assign lane_synced = f_synced(state);
  assign realign_en  = (state == S_SEEK);
  assign fault_req   = !lane_synced;

  // R2: loss of signal wins over every other input
  p_los_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sig_lost |=> realign_en && !lane_synced);

  // R3: leaving the seek state on a comma stops realignment
  p_seek_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_load |=> !realign_en);

  // R6: any error while acquiring returns to seek
  p_conf_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    f_in_conf(state) && code_err |=> state == S_SEEK);

  // R8: first error in sync keeps the lane up at miss level 1
  p_lock_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOCK) && code_err |=> state == S_SLIP1 && lane_synced);

  // R9: deeper levels recover only to level 1
  p_deep_recover_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SLIP2 || state == S_SLIP3) && run_done |=> state == S_SLIP1);

  // R11: a cycle without a code group changes nothing
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !code_vld && !sig_lost |=> $stable(state) && $stable(align_pos));

endmodule

// File: tb/tb_lane_sync_fsm.sv
module tb_lane_sync_fsm;
  localparam int POS_W = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic code_vld, comma_det, dec_err, disp_err, sig_lost;
  logic [POS_W-1:0] comma_pos;
  logic lane_synced, realign_en, fault_req;
  logic [POS_W-1:0] align_pos;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lane_sync_fsm #(.POS_W(POS_W), .RUN_LEN(3)) dut (
    .clk(clk), .rst_n(rst_n), .code_vld(code_vld), .comma_det(comma_det),
    .comma_pos(comma_pos), .dec_err(dec_err), .disp_err(disp_err),
    .sig_lost(sig_lost), .lane_synced(lane_synced), .realign_en(realign_en),
    .align_pos(align_pos), .fault_req(fault_req)
  );

  // vector: req[14:11] vld[10] comma[9] pos[8:5] derr[4] rerr[3] los[2] sync[1] realign[0]
  localparam int NV = 28;
  localparam logic [14:0] VEC [NV] = '{
    {4'd3,  1'b1,1'b1,4'd3, 3'b000, 2'b00},  // R3 first comma, capture 3
    {4'd4,  1'b1,1'b1,4'd3, 3'b000, 2'b00},  // R4
    {4'd4,  1'b1,1'b1,4'd3, 3'b000, 2'b00},  // R4
    {4'd5,  1'b1,1'b1,4'd5, 3'b000, 2'b10},  // R5 last step accepts offset 5
    {4'd8,  1'b1,1'b0,4'd0, 3'b100, 2'b10},  // R8 to level 1
    {4'd8,  1'b1,1'b0,4'd0, 3'b000, 2'b10},
    {4'd11, 1'b0,1'b0,4'd0, 3'b100, 2'b10},  // R11 invalid error ignored
    {4'd8,  1'b1,1'b0,4'd0, 3'b000, 2'b10},
    {4'd8,  1'b1,1'b0,4'd0, 3'b000, 2'b10},  // back to sync
    {4'd9,  1'b1,1'b0,4'd0, 3'b100, 2'b10},  // R9 level 1
    {4'd9,  1'b1,1'b0,4'd0, 3'b010, 2'b10},  // level 2
    {4'd9,  1'b1,1'b0,4'd0, 3'b000, 2'b10},
    {4'd9,  1'b1,1'b0,4'd0, 3'b000, 2'b10},
    {4'd9,  1'b1,1'b0,4'd0, 3'b000, 2'b10},  // level 1, not sync
    {4'd9,  1'b1,1'b0,4'd0, 3'b100, 2'b10},  // level 2
    {4'd9,  1'b1,1'b0,4'd0, 3'b100, 2'b10},  // level 3
    {4'd9,  1'b1,1'b0,4'd0, 3'b100, 2'b01},  // drop: proves level 1 above
    {4'd12, 1'b1,1'b1,4'd6, 3'b100, 2'b01},  // R12 comma with error stays
    {4'd3,  1'b1,1'b1,4'd7, 3'b000, 2'b00},  // capture 7
    {4'd5,  1'b1,1'b1,4'd2, 3'b000, 2'b01},  // R5 mismatch in step 1
    {4'd5,  1'b1,1'b1,4'd7, 3'b000, 2'b00},
    {4'd5,  1'b1,1'b1,4'd7, 3'b000, 2'b00},
    {4'd5,  1'b1,1'b1,4'd1, 3'b000, 2'b01},  // mismatch in step 2
    {4'd3,  1'b1,1'b1,4'd4, 3'b000, 2'b00},
    {4'd6,  1'b1,1'b0,4'd0, 3'b010, 2'b01},  // R6 disparity error
    {4'd6,  1'b1,1'b1,4'd4, 3'b000, 2'b00},
    {4'd6,  1'b1,1'b1,4'd4, 3'b000, 2'b00},
    {4'd12, 1'b1,1'b1,4'd4, 3'b100, 2'b01}   // comma+error in step 2
  };

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  task automatic check(int req, logic es, logic er);
    n_chk++;
    if (lane_synced !== es || realign_en !== er || fault_req !== !es) begin
      n_bad++;
      $display("FAIL R%0d: sync/realign/fault = %b%b%b expected %b%b%b",
               req, lane_synced, realign_en, fault_req, es, er, !es);
    end
  endtask

  task automatic check_pos(int req, logic [POS_W-1:0] ep);
    n_chk++;
    if (align_pos !== ep) begin
      n_bad++;
      $display("FAIL R%0d: align_pos = %0d expected %0d", req, align_pos, ep);
    end
  endtask

  // called at a negedge; returns at the negedge after the edge that used the code
  task automatic drive(logic v, logic c, logic [POS_W-1:0] p, logic de, logic re, logic l);
    code_vld = v; comma_det = c; comma_pos = p; dec_err = de; disp_err = re; sig_lost = l;
    @(posedge clk);
    @(negedge clk);
    code_vld = 0; comma_det = 0; dec_err = 0; disp_err = 0; sig_lost = 0;
  endtask

  task automatic acquire(logic [POS_W-1:0] p);
    for (int k = 0; k < 4; k++) drive(1, 1, p, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      report();
    end
  end

  initial begin
    rst_n = 0; code_vld = 0; comma_det = 0; comma_pos = '0;
    dec_err = 0; disp_err = 0; sig_lost = 0;
    repeat (3) @(negedge clk);
    check(1, 0, 1);          // R1 reset state
    check_pos(1, 4'd0);      // R1
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][10], VEC[i][9], VEC[i][8:5], VEC[i][4], VEC[i][3], VEC[i][2]);
      check(int'(VEC[i][14:11]), VEC[i][1], VEC[i][0]);
    end
    check_pos(3, 4'd4);      // R3 last capture, comma+error did not recapture

    // R4: three commas are not enough
    drive(1, 1, 4'd9, 0, 0, 0); drive(1, 1, 4'd9, 0, 0, 0); drive(1, 1, 4'd9, 0, 0, 0);
    check(4, 0, 0);
    drive(1, 1, 4'd9, 0, 0, 0);
    check(4, 1, 0);
    check_pos(3, 4'd9);

    // R11: invalid comma in seek state does not capture
    drive(0, 0, 4'd0, 0, 0, 1);
    check(2, 0, 1);          // R2 loss of signal from sync
    drive(0, 1, 4'd2, 0, 0, 0);
    check(11, 0, 1);
    check_pos(11, 4'd9);

    // R2: loss of signal beats a good comma in the last step
    drive(1, 1, 4'd5, 0, 0, 0); drive(1, 1, 4'd5, 0, 0, 0); drive(1, 1, 4'd5, 0, 0, 0);
    drive(1, 1, 4'd5, 0, 0, 1);
    check(2, 0, 1);

    // R10: clean codes before an error do not carry into the next level
    acquire(4'd1);
    drive(1, 0, 0, 1, 0, 0);                            // level 1
    drive(1, 0, 0, 0, 0, 0); drive(1, 0, 0, 0, 0, 0);
    drive(1, 0, 0, 1, 0, 0);                            // level 2, count restarts
    drive(1, 0, 0, 0, 0, 0);                            // only one clean code
    drive(1, 0, 0, 1, 0, 0);                            // level 3
    check(10, 1, 0);
    drive(1, 0, 0, 0, 1, 0);                            // drop
    check(10, 0, 1);

    // R8/R7: recovered lane needs four errors to drop
    acquire(4'd2);
    drive(1, 0, 0, 1, 0, 0);
    repeat (3) drive(1, 0, 0, 0, 0, 0);
    repeat (3) drive(1, 0, 0, 1, 0, 0);
    check(7, 1, 0);          // R7 still synced at level 3
    drive(1, 0, 0, 1, 0, 0);
    check(8, 0, 1);

    // R1: reset mid-run
    acquire(4'd6);
    rst_n = 0;
    @(negedge clk);
    check(1, 0, 1);
    check_pos(1, 4'd0);

    done = 1'b1;
    report();
  end

endmodule